// File: doc/BRIEF.md
# Host Buffer and Dispatch Controller

This block sits on the slave side of a processor bus and feeds a set of execution units through a pair of word buffers. The host, or a DMA engine it programs, pushes 32-bit words into an input buffer. A destination code in the command/status register selects the one execution unit that receives them. A count register then moves that many words out of the input buffer through the selected unit, and the results collect in an output buffer for the host to drain. The execution units here are stand-in echo units. Each one returns every word XORed with a key derived from its code.

Two request lines tell a DMA engine when it may move data. The input request stays high while the input buffer has room. The output request stays high while the output buffer holds results. This lets the host preload the next job while the current one is still running. Each unit raises a flag in the command/status register when it delivers the last word of a job. A mask register filters these flags, and one registered interrupt line reports the OR of the flags that are not masked.

Top module: `hbdc_top`

## Requirements
- R1: After reset, the command/status register, the mask register and the level register all read 0. `in_dreq` is 1, `out_dreq` is 0 and `irq` is 0.
- R2: Bits [2:0] of the command/status register (address 0x100) hold the destination code, with valid codes 1 to 5. Only the unit with that code receives words. Each result equals the input word XOR the code byte repeated four times (code 3 gives 0x03030303). Results leave in input order.
- R3: A write of N to the count register (address 0x102) starts a job only when no job is busy and the code is valid. The job moves exactly N words and leaves the rest in the input buffer. If the input buffer runs short, the job waits for more words. Reading the count register returns the number of words still to move.
- R4: `in_dreq` is 1 exactly while the input buffer holds fewer than 128 words. `out_dreq` is 1 exactly while the output buffer holds at least one word.
- R5: Each buffer holds 128 words of 32 bits. A push into a full input buffer is discarded. A job stalls while the output buffer has no room for its results.
- R6: The mask register (address 0x101, bits [4:0]) has bit i for unit code i+1. A 1 masks that unit, and the register resets to 0. `irq` is the OR of the unmasked flags and follows them one cycle later.
- R7: Flag bit 8+i of the command/status register is set when the unit with code i+1 delivers the last word of a job. Writing 1 to that bit clears it.
- R8: A command/status write that carries a different destination code while a job is busy leaves the code unchanged and sets the error bit 16. Writing 1 to bit 16 clears it. Bit 17 reads 1 while a job is busy.
- R9: Register reads return data one cycle after `rd_en`, and unused bits read 0. The level register (address 0x103) holds the input fill in bits [7:0] and the output fill in bits [23:16]. Writes to addresses 0x000–0x07F push into the input buffer. Reads from 0x080–0x0FF pop the output buffer, and a pop from an empty output buffer returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read strobe for one cycle |
| addr | input | 12 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| in_dreq | output | 1 | Input buffer has free space |
| out_dreq | output | 1 | Output buffer holds data |
| irq | output | 1 | Summary interrupt |

## Verification
The assertions assume that the host drives at most one of `wr_en` and `rd_en` in a cycle. They also assume the host starts a job only through the count register, so the busy window is the only period in which the destination code must hold still. The stimulus meets both assumptions by issuing every bus access from one sequential task. It chooses random unit codes, word values and job lengths, always within the buffer depth. Directed cases then push past a full input buffer, stall a job behind a full output buffer and attempt a reroute during a long job.

// File: rtl/hbdc_pkg.sv
package hbdc_pkg;
  localparam logic [11:0] A_CMD   = 12'h100;
  localparam logic [11:0] A_MASK  = 12'h101;
  localparam logic [11:0] A_COUNT = 12'h102;
  localparam logic [11:0] A_LEVEL = 12'h103;

  // Key applied by the stand-in unit with a given code
  function automatic logic [31:0] echo_key(input logic [2:0] code);
    return {4{{5'b0, code}}};
  endfunction
endpackage

// File: rtl/hbdc_fifo.sv
module hbdc_fifo #(
  parameter int DEPTH = 128,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] fill
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  assign do_push = push && (fill != CW'(DEPTH));
  assign do_pop  = pop && (fill != '0);

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  // registered read port, maps onto a block RAM output register
  always_ff @(posedge clk) begin
    if (rst)         pop_data <= '0;
    else if (do_pop) pop_data <= mem[rp];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      fill <= fill + CW'(do_push) - CW'(do_pop);
    end
  end
endmodule

// File: rtl/hbdc_echo_unit.sv
module hbdc_echo_unit #(
  parameter logic [2:0] CODE = 3'd1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic        in_last,
  input  logic [31:0] in_data,
  output logic        out_valid,
  output logic        out_last,
  output logic [31:0] out_data
);
  import hbdc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_last  <= in_valid && in_last;
      if (in_valid) out_data <= in_data ^ echo_key(CODE);
    end
  end
endmodule

// File: rtl/hbdc_top.sv
module hbdc_top #(
  parameter int DEPTH  = 128,
  parameter int UNITS  = 5,
  localparam int CW    = $clog2(DEPTH) + 1,
  localparam int CODEW = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [11:0] addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        in_dreq,
  output logic        out_dreq,
  output logic        irq
);
  import hbdc_pkg::*;

  logic [CODEW-1:0] dest;
  logic [UNITS-1:0] mask, flags, unit_valid;
  logic [UNITS-1:0] eu_valid, eu_last;
  logic [31:0]      eu_data [UNITS];
  logic             route_err, s1, s1_last, busy, issue, eu_any;
  logic [CW-1:0]    remaining, in_fill, out_fill;
  logic [31:0]      in_q, out_q, res_data, reg_q, cmd_word, level_word;
  logic             from_out, code_ok;
  logic             in_win, out_win, w_cmd, w_mask, w_count;

  assign in_win  = addr[11:7] == 5'd0;
  assign out_win = addr[11:7] == 5'd1;
  assign w_cmd   = wr_en && addr == A_CMD;
  assign w_mask  = wr_en && addr == A_MASK;
  assign w_count = wr_en && addr == A_COUNT;
  assign code_ok = dest != '0 && dest <= CODEW'(UNITS);

  hbdc_fifo #(.DEPTH(DEPTH), .W(32)) u_in_buf (
    .clk(clk), .rst(rst), .push(wr_en && in_win), .push_data(wdata),
    .pop(issue), .pop_data(in_q), .fill(in_fill));

  hbdc_fifo #(.DEPTH(DEPTH), .W(32)) u_out_buf (
    .clk(clk), .rst(rst), .push(eu_any), .push_data(res_data),
    .pop(rd_en && out_win), .pop_data(out_q), .fill(out_fill));

  // issue only with room reserved for every word already in flight
  assign issue = remaining != '0 && in_fill != '0 &&
                 ({1'b0, out_fill} + (CW+1)'(s1) + (CW+1)'(eu_any)) < (CW+1)'(DEPTH);
  assign busy  = remaining != '0 || s1 || eu_any;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1      <= 1'b0;
      s1_last <= 1'b0;
    end else begin
      s1      <= issue;
      s1_last <= issue && remaining == CW'(1);
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < UNITS; gi++) begin : g_unit
      assign unit_valid[gi] = s1 && dest == CODEW'(gi + 1);
      hbdc_echo_unit #(.CODE(3'(gi + 1))) u_eu (
        .clk(clk), .rst(rst), .in_valid(unit_valid[gi]), .in_last(s1_last),
        .in_data(in_q), .out_valid(eu_valid[gi]), .out_last(eu_last[gi]),
        .out_data(eu_data[gi]));
    end
  endgenerate

  assign eu_any = |eu_valid;
  always_comb begin
    res_data = '0;
    for (int i = 0; i < UNITS; i++)
      if (eu_valid[i]) res_data = res_data | eu_data[i];
  end

  // control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      dest      <= '0;
      mask      <= '0;
      flags     <= '0;
      route_err <= 1'b0;
      remaining <= '0;
    end else begin
      if (w_mask) mask <= wdata[UNITS-1:0];
      if (w_cmd) begin
        if (!busy) dest <= wdata[CODEW-1:0];
        if (wdata[16]) route_err <= 1'b0;
        flags <= (flags & ~wdata[8 +: UNITS]) | eu_last;
      end else begin
        flags <= flags | eu_last;
      end
      if (w_cmd && busy && wdata[CODEW-1:0] != dest) route_err <= 1'b1;
      if (w_count && !busy && code_ok) remaining <= wdata[CW-1:0];
      else if (issue)                  remaining <= remaining - 1'b1;
    end
  end

  always_comb begin
    cmd_word              = '0;
    cmd_word[CODEW-1:0]   = dest;
    cmd_word[8 +: UNITS]  = flags;
    cmd_word[16]          = route_err;
    cmd_word[17]          = busy;
    level_word            = '0;
    level_word[CW-1:0]    = in_fill;
    level_word[16 +: CW]  = out_fill;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q    <= '0;
      from_out <= 1'b0;
      irq      <= 1'b0;
    end else begin
      from_out <= rd_en && out_win && out_fill != '0;
      reg_q    <= '0;
      if (rd_en) begin
        case (addr)
          A_CMD:   reg_q <= cmd_word;
          A_MASK:  reg_q <= 32'(mask);
          A_COUNT: reg_q <= 32'(remaining);
          A_LEVEL: reg_q <= level_word;
          default: reg_q <= '0;
        endcase
      end
      irq <= |(flags & ~mask);
    end
  end

  assign rdata    = from_out ? out_q : reg_q;
  assign in_dreq  = in_fill != CW'(DEPTH);
  assign out_dreq = out_fill != '0;
endmodule

// File: rtl/hbdc_chk.sv
module hbdc_chk #(
  parameter int DEPTH = 128,
  parameter int UNITS = 5,
  parameter int CW    = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             busy,
  input logic [2:0]       dest,
  input logic [CW-1:0]    in_fill,
  input logic [CW-1:0]    out_fill,
  input logic [CW-1:0]    remaining,
  input logic [UNITS-1:0] flags,
  input logic [UNITS-1:0] mask,
  input logic [UNITS-1:0] unit_valid,
  input logic             irq
);
  // R8: the destination code holds while a job is busy
  a_r8_dest_hold: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(dest));
  // R5: buffers never exceed their depth
  a_r5_in_bound: assert property (@(posedge clk) disable iff (rst)
    in_fill <= CW'(DEPTH));
  a_r5_out_bound: assert property (@(posedge clk) disable iff (rst)
    out_fill <= CW'(DEPTH));
  // R2: at most one unit receives a word in any cycle
  a_r2_one_unit: assert property (@(posedge clk) disable iff (rst)
    $onehot0(unit_valid));
  // R3: the remaining count never grows during a job
  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    busy |=> remaining <= $past(remaining));
  // R6: no unmasked flag means the interrupt is low next cycle
  a_r6_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    ((flags & ~mask) == '0) |=> !irq);
endmodule

bind hbdc_top hbdc_chk #(.DEPTH(DEPTH), .UNITS(UNITS), .CW(CW)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .dest(dest), .in_fill(in_fill),
  .out_fill(out_fill), .remaining(remaining), .flags(flags), .mask(mask),
  .unit_valid(unit_valid), .irq(irq));

// File: tb/hbdc_top_tb.sv
module hbdc_top_tb;
  logic        clk = 1'b0;
  logic        rst, wr_en, rd_en;
  logic [11:0] addr;
  logic [31:0] wdata, rdata;
  logic        in_dreq, out_dreq, irq;
  int          n_chk = 0, n_bad = 0;
  logic [31:0] q [128];
  logic [31:0] extra;

  always #10 clk = ~clk;

  hbdc_top u_dut (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .in_dreq(in_dreq), .out_dreq(out_dreq), .irq(irq));

  function automatic logic [31:0] expect_word(input int code, input logic [31:0] w);
    logic [7:0] b;
    b = 8'(code);
    return w ^ {b, b, b, b};
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      rd(12'h100, v);
      if (!v[17]) return;
    end
  endtask

  task automatic run_job(input int code, input int n);
    logic [31:0] v;
    for (int i = 0; i < n; i++) begin q[i] = $urandom; wr(12'h000, q[i]); end
    rd(12'h103, v); chk(v, 32'(n), "R9 input level after pushes");
    wr(12'h100, 32'(code) | 32'h1F00);
    wr(12'h102, 32'(n));
    wait_done();
    rd(12'h103, v); chk(v, 32'(n) << 16, "R3 levels after job");
    chk({31'b0, out_dreq}, 1, "R4 out_dreq with data");
    rd(12'h100, v);
    chk(v, 32'(code) | (32'h100 << (code - 1)), "R7 flag of routed unit");
    for (int i = 0; i < n; i++) begin
      rd(12'h080, v); chk(v, expect_word(code, q[i]), "R2 echoed word");
    end
    chk({31'b0, out_dreq}, 0, "R4 out_dreq drained");
    idle(2);
    chk({31'b0, irq}, 1, "R6 irq from unmasked flag");
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v;
    int k;
    v = $urandom(32'd2024);
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(3); rst = 1'b0; idle(1);

    rd(12'h100, v); chk(v, 0, "R1 cmd reset");
    rd(12'h101, v); chk(v, 0, "R1 mask reset");
    rd(12'h103, v); chk(v, 0, "R1 level reset");
    chk({31'b0, in_dreq}, 1, "R1 in_dreq reset");
    chk({31'b0, out_dreq}, 0, "R1 out_dreq reset");
    chk({31'b0, irq}, 0, "R1 irq reset");
    rd(12'h080, v); chk(v, 0, "R9 pop of empty output");
    wr(12'h101, 32'hFFFF_FFFF); rd(12'h101, v); chk(v, 32'h1F, "R9 unused mask bits");
    wr(12'h101, 0);

    for (int j = 0; j < 10; j++) run_job(1 + int'($urandom % 5), 1 + int'($urandom % 24));

    // mask handling on the last job's flag
    rd(12'h100, v); k = int'(v[2:0]);
    wr(12'h101, 32'(1) << (k - 1)); idle(2);
    chk({31'b0, irq}, 0, "R6 masked flag gives no irq");
    wr(12'h101, 32'h1F & ~(32'(1) << (k - 1))); idle(2);
    chk({31'b0, irq}, 1, "R6 other masks leave irq");
    wr(12'h101, 0);
    wr(12'h100, 32'(k) | (32'h100 << (k - 1))); idle(2);
    chk({31'b0, irq}, 0, "R7 flag cleared by write one");
    rd(12'h100, v); chk(v, 32'(k), "R7 flag reads zero");

    // partial count, then preload continues
    for (int i = 0; i < 10; i++) begin q[i] = $urandom; wr(12'h000, q[i]); end
    wr(12'h100, 32'd2); wr(12'h102, 32'd4); wait_done();
    rd(12'h103, v); chk(v, (32'd4 << 16) | 32'd6, "R3 partial count levels");
    rd(12'h102, v); chk(v, 0, "R3 remaining zero");
    wr(12'h102, 32'd6); wait_done();
    for (int i = 0; i < 10; i++) begin
      rd(12'h080, v); chk(v, expect_word(2, q[i]), "R3 words in order");
    end
    // job waits for input
    wr(12'h102, 32'd3);
    wr(12'h000, 32'hA5A5_0001); idle(10);
    rd(12'h102, v); chk(v, 2, "R3 waits for more words");
    wr(12'h000, 32'hA5A5_0002); wr(12'h000, 32'hA5A5_0003); wait_done();
    for (int i = 1; i <= 3; i++) begin
      rd(12'h080, v); chk(v, expect_word(2, 32'hA5A5_0000 + 32'(i)), "R2 code 2 key");
    end

    // full input buffer
    for (int i = 0; i < 128; i++) begin q[i] = $urandom; wr(12'h000, q[i]); end
    chk({31'b0, in_dreq}, 0, "R4 in_dreq low when full");
    wr(12'h000, 32'hDEAD_BEEF);
    rd(12'h103, v); chk(v, 128, "R5 push into full discarded");
    wr(12'h100, 32'd3 | 32'h1F00); wr(12'h102, 32'd128);
    wr(12'h100, 32'd5);
    rd(12'h100, v); chk(v & 32'h3_0007, 32'h3_0003, "R8 reroute ignored, error set");
    wait_done();
    rd(12'h103, v); chk(v, 32'd128 << 16, "R5 output full after job");
    chk({31'b0, in_dreq}, 1, "R4 in_dreq after drain");
    // output full stalls the next job
    extra = $urandom; wr(12'h000, extra); wr(12'h102, 32'd1); idle(20);
    rd(12'h100, v); chk({31'b0, v[17]}, 1, "R5 job stalled by full output");
    rd(12'h102, v); chk(v, 1, "R5 stalled word not moved");
    rd(12'h080, v); chk(v, expect_word(3, q[0]), "R5 first output word");
    wait_done();
    for (int i = 1; i < 128; i++) begin
      rd(12'h080, v); chk(v, expect_word(3, q[i]), "R5 full-depth word");
    end
    rd(12'h080, v); chk(v, expect_word(3, extra), "R5 stalled word released");
    wr(12'h100, 32'd3 | 32'h1_1F00);
    rd(12'h100, v); chk(v, 32'd3, "R8 error cleared by write one");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule